// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This peripheral keeps time as a plain 32-bit binary count of seconds. A slow tick, taken either from an input pin or from an internal clock divider chosen by a parameter, advances the count once per second while counting is enabled. Software sees a small word-addressed register set. It holds a control and status word, the seconds count, an alarm compare value, a free storage word for regulator settings, a hibernate request word and a scratchpad that survives software restarts.

Two event flags are sticky: one marks each second, the other marks an alarm match. Software clears a flag by writing 0 to its bit. Writing 1 leaves the flag as it is, so a read-modify-write that forces both flag bits high loses no event. An interrupt line combines each flag with its own enable bit. Every register write is accepted only while a write-ready status bit is set. After each accepted write that bit stays low for a fixed number of slow ticks. A write to the seconds register is held pending and is copied into the counter on the next tick.

Top module: `secs_rtc`

## Requirements
- R1: After reset the seconds, alarm, regulator and scratchpad words read 0. The control word reads 0x80, meaning only write-ready (bit 7) is set. irq_o and hib_o are low.
- R2: An accepted write clears write-ready (control bit 7) for BUSY_TICKS slow ticks, default 2, and the bit then returns to 1. A write issued while the bit is 0 changes nothing.
- R3: While the counter enable (control bit 0) is 1, each tick adds 1 to the seconds word (word address 1), and 0xFFFFFFFF wraps to 0. While the enable is 0, the count holds.
- R4: A write to the seconds word leaves the count unchanged until the next tick. That tick loads the written value exactly, with no increment.
- R5: Every tick that increments the counter sets the one-second flag (control bit 6).
- R6: Writing 0 to control bit 6 or to control bit 4 clears that flag. Writing 1 leaves the flag as it was.
- R7: The alarm flag (control bit 4) sets when a tick brings the count equal to the alarm word (word address 2) while alarm enable (control bit 2) is 1. It does not set while alarm enable is 0.
- R8: irq_o is high exactly when bit 6 and its enable bit 5 are both set, or when bit 4 and its enable bit 3 are both set.
- R9: Writing the value 1 to the hibernate word (word address 8) raises hib_o for one clock cycle. Writing any other value there leaves hib_o low.
- R10: The alarm word, the regulator word (word address 3) and the scratchpad word (word address 13) read back the value last written. Unmapped word addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | One-cycle slow tick pulse, used when CLK_DIV is 0 |
| addr_i | input | 4 | Word address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe; rdata_o is 0 when it is low |
| rdata_o | output | 32 | Read data for addr_i, valid in the same cycle |
| irq_o | output | 1 | Interrupt request |
| hib_o | output | 1 | One-cycle hibernate request pulse |

## Verification
The hardest case to reach is the alarm match. It happens only on a tick, only while alarm enable is set, and every write needed to arm it first costs two ticks of write-ready delay, which also move the counter. The stimulus reads the current count, writes an alarm value two seconds ahead while counting is stopped, and then enables counting and the alarm in one control write. The match then falls on the second tick after that write. The same steps are repeated with alarm enable cleared to show that the flag stays clear.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADR_CTRL    = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_SECS    = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_ALARM   = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_REGUL   = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_HIB     = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_SCRATCH = 4'd13;

    localparam int CB_EN   = 0;
    localparam int CB_AE   = 2;
    localparam int CB_AIE  = 3;
    localparam int CB_AF   = 4;
    localparam int CB_SIE  = 5;
    localparam int CB_SF   = 6;
    localparam int CB_RDY  = 7;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t secs;
        word_t alarm;
        word_t regul;
        word_t scratch;
        word_t load;
        logic  pend;
        logic  en;
        logic  alm_en;
        logic  alm_ie;
        logic  alm_flag;
        logic  sec_ie;
        logic  sec_flag;
        logic  hib;
    } core_t;
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int DIV = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic tick_o
);
    generate
        if (DIV == 0) begin : g_ext
            assign tick_o = tick_i;
        end else begin : g_div
            localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
            logic [CW-1:0] cnt_d, cnt_q;
            logic          wrap;
            logic          unused_tick;

            assign unused_tick = tick_i;
            assign wrap        = (cnt_q == CW'(DIV - 1));

            always_comb begin
                cnt_d = wrap ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = wrap;
        end
    endgenerate
endmodule

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate #(
    parameter int BUSY_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic wr_acc_i,
    output logic rdy_o
);
    localparam int BW = $clog2(BUSY_TICKS + 1);

    logic [BW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_acc_i) begin
            cnt_d = BW'(BUSY_TICKS);
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign rdy_o = (cnt_q == '0);
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
    import rtc_pkg::*;
#(
    parameter int BUSY_TICKS = 2,
    parameter int CLK_DIV    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              rd_en_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              hib_o
);
    logic  tick_w;
    logic  wr_rdy_w;
    logic  wr_ok_w;
    core_t s_d, s_q;
    logic  upd, inc;
    word_t ctrl_w;
    word_t rd_mux;

    rtc_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .tick_o (tick_w)
    );

    assign wr_ok_w = wr_en_i & wr_rdy_w;

    rtc_wr_gate #(.BUSY_TICKS(BUSY_TICKS)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_w),
        .wr_acc_i (wr_ok_w),
        .rdy_o    (wr_rdy_w)
    );

    always_comb begin
        s_d     = s_q;
        s_d.hib = 1'b0;
        upd     = 1'b0;
        inc     = 1'b0;

        // tick boundary: pending load beats increment
        if (tick_w) begin
            if (s_q.pend) begin
                s_d.secs = s_q.load;
                s_d.pend = 1'b0;
                upd      = 1'b1;
            end else if (s_q.en) begin
                s_d.secs = s_q.secs + 1'b1;
                upd      = 1'b1;
                inc      = 1'b1;
            end
        end

        if (wr_ok_w) begin
            case (addr_i)
                ADR_CTRL: begin
                    s_d.en     = wdata_i[CB_EN];
                    s_d.alm_en = wdata_i[CB_AE];
                    s_d.alm_ie = wdata_i[CB_AIE];
                    s_d.sec_ie = wdata_i[CB_SIE];
                    if (!wdata_i[CB_SF]) s_d.sec_flag = 1'b0;
                    if (!wdata_i[CB_AF]) s_d.alm_flag = 1'b0;
                end
                ADR_SECS: begin
                    s_d.load = wdata_i;
                    s_d.pend = 1'b1;
                end
                ADR_ALARM:   s_d.alarm   = wdata_i;
                ADR_REGUL:   s_d.regul   = wdata_i;
                ADR_SCRATCH: s_d.scratch = wdata_i;
                ADR_HIB:     s_d.hib     = (wdata_i == word_t'(1));
                default: ;
            endcase
        end

        // new events win over a same-cycle clear
        if (inc) s_d.sec_flag = 1'b1;
        if (upd && s_q.alm_en && (s_d.secs == s_q.alarm)) s_d.alm_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        ctrl_w         = '0;
        ctrl_w[CB_EN]  = s_q.en;
        ctrl_w[CB_AE]  = s_q.alm_en;
        ctrl_w[CB_AIE] = s_q.alm_ie;
        ctrl_w[CB_AF]  = s_q.alm_flag;
        ctrl_w[CB_SIE] = s_q.sec_ie;
        ctrl_w[CB_SF]  = s_q.sec_flag;
        ctrl_w[CB_RDY] = wr_rdy_w;
    end

    always_comb begin
        case (addr_i)
            ADR_CTRL:    rd_mux = ctrl_w;
            ADR_SECS:    rd_mux = s_q.secs;
            ADR_ALARM:   rd_mux = s_q.alarm;
            ADR_REGUL:   rd_mux = s_q.regul;
            ADR_SCRATCH: rd_mux = s_q.scratch;
            default:     rd_mux = '0;
        endcase
    end

    assign rdata_o = rd_en_i ? rd_mux : '0;
    assign irq_o   = (s_q.sec_flag & s_q.sec_ie) | (s_q.alm_flag & s_q.alm_ie);
    assign hib_o   = s_q.hib;
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_rdy,
    input logic              en,
    input logic              pend,
    input logic [WORD_W-1:0] secs,
    input logic [WORD_W-1:0] scratch,
    input logic              hib
);
    // R2: a write while busy leaves the scratchpad alone
    assert_busy_write_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_rdy && addr == ADR_SCRATCH) |=> $stable(scratch));

    // R2: ready only falls after a write strobe
    assert_ready_falls_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_rdy) |-> $past(wr_en));

    // R3: enabled tick with nothing pending adds one
    assert_tick_increments_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en && !pend) |=> (secs == $past(secs) + 1'b1));

    // R3: disabled tick with nothing pending holds the count
    assert_disabled_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !en && !pend) |=> $stable(secs));

    // R4: the count only moves on a tick
    assert_no_change_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(secs));

    // R9: hibernate request lasts one cycle
    assert_hib_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hib |=> !hib);
endmodule

bind secs_rtc rtc_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_w),
    .wr_en   (wr_en_i),
    .addr    (addr_i),
    .wr_rdy  (wr_rdy_w),
    .en      (s_q.en),
    .pend    (s_q.pend),
    .secs    (s_q.secs),
    .scratch (s_q.scratch),
    .hib     (hib_o)
);

// File: tb/test_secs_rtc.sv
`timescale 1ns/1ps
module test_secs_rtc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic        rd_en_i = 1'b0;
    logic [31:0] rdata_o;
    logic        irq_o;
    logic        hib_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    secs_rtc i_secs_rtc (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rd_en_i(rd_en_i),
        .rdata_o(rdata_o), .irq_o(irq_o), .hib_o(hib_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr_i = a; rd_en_i = 1'b1;
        #0.5;
        d = rdata_o;
        rd_en_i = 1'b0;
    endtask

    task automatic tk();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd0, v);  chk("R1 ctrl", v, 32'h80);
        rd(4'd1, v);  chk("R1 secs", v, 0);
        rd(4'd2, v);  chk("R1 alarm", v, 0);
        rd(4'd3, v);  chk("R1 regul", v, 0);
        rd(4'd13, v); chk("R1 scratch", v, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);
        chk("R1 hib", {31'd0, hib_o}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(4'd13, 32'hA5A5_1234); tk(); tk();
        wr(4'd3, 32'hDEAD_BEEF);  tk(); tk();
        wr(4'd2, 32'h0000_0055);  tk(); tk();
        rd(4'd13, v); chk("R10 scratch", v, 32'hA5A5_1234);
        rd(4'd3, v);  chk("R10 regul", v, 32'hDEAD_BEEF);
        rd(4'd2, v);  chk("R10 alarm", v, 32'h55);
        rd(4'd5, v);  chk("R10 unmapped", v, 0);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        wr(4'd13, 32'h1111);
        rd(4'd0, v); chk("R2 busy after write", v, 32'h00);
        wr(4'd13, 32'h2222);
        tk();
        rd(4'd0, v); chk("R2 busy after one tick", v, 32'h00);
        tk();
        rd(4'd0, v); chk("R2 ready after two ticks", v, 32'h80);
        rd(4'd13, v); chk("R2 busy write ignored", v, 32'h1111);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wr(4'd1, 32'd100);
        rd(4'd1, v); chk("R4 load waits for tick", v, 0);
        tk();
        rd(4'd1, v); chk("R4 loaded on tick", v, 100);
        tk();
        wr(4'd0, 32'h01); tk(); tk();
        rd(4'd1, v); chk("R3 counts", v, 102);
        rd(4'd0, v); chk("R5 second flag set", v, 32'hC1);
        wr(4'd1, 32'd500); tk();
        rd(4'd1, v); chk("R4 load no increment", v, 500);
        tk();
        rd(4'd1, v); chk("R3 counts after load", v, 501);
        wr(4'd0, 32'h40); tk(); tk();
        rd(4'd1, v); chk("R3 disabled holds", v, 501);
        rd(4'd0, v); chk("R6 write 1 keeps flag", v, 32'hC0);
        wr(4'd1, 32'hFFFF_FFFF); tk(); tk();
        wr(4'd0, 32'h41); tk();
        rd(4'd1, v); chk("R3 wrap", v, 0);
        tk();
        rd(4'd1, v); chk("R3 after wrap", v, 1);
    endtask

    task automatic t_flags();
        logic [31:0] v;
        wr(4'd0, 32'h01);
        rd(4'd0, v); chk("R6 write 0 clears second flag", v, 32'h01);
        tk(); tk();
        rd(4'd0, v); chk("R5 flag set again", v, 32'hC1);
        wr(4'd0, 32'h60);
        chk("R8 irq from second flag", {31'd0, irq_o}, 1);
        tk(); tk();
        wr(4'd0, 32'h20);
        chk("R8 irq drops on clear", {31'd0, irq_o}, 0);
        rd(4'd0, v); chk("R6 cleared with enable", v, 32'h20);
        tk(); tk();
    endtask

    task automatic t_alarm();
        logic [31:0] s, v;
        rd(4'd1, s);
        wr(4'd2, s + 2); tk(); tk();
        wr(4'd0, 32'h0D);
        tk();
        rd(4'd0, v); chk("R7 no alarm before match", {31'd0, v[4]}, 0);
        chk("R8 irq low before match", {31'd0, irq_o}, 0);
        tk();
        rd(4'd1, v); chk("R7 count at match", v, s + 2);
        rd(4'd0, v); chk("R7 alarm flag on match", v, 32'hDD);
        chk("R8 irq from alarm", {31'd0, irq_o}, 1);
        wr(4'd0, 32'h09);
        chk("R8 irq drops on alarm clear", {31'd0, irq_o}, 0);
        tk(); tk();
        wr(4'd2, s + 6); tk(); tk();
        rd(4'd1, v); chk("R7 count reached alarm", v, s + 6);
        rd(4'd0, v); chk("R7 no flag without alarm enable", v, 32'hC9);
        chk("R8 irq stays low", {31'd0, irq_o}, 0);
    endtask

    task automatic t_hib();
        wr(4'd8, 32'd2);
        chk("R9 other value no pulse", {31'd0, hib_o}, 0);
        tk(); tk();
        wr(4'd8, 32'd1);
        chk("R9 pulse", {31'd0, hib_o}, 1);
        @(negedge clk);
        chk("R9 pulse ends", {31'd0, hib_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_gate();
        t_count();
        t_flags();
        t_alarm();
        t_hib();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule